// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital core of an 8-bit successive-approximation converter that sits behind a microprocessor-style bus. The host starts a conversion by pulling chip select and write low together and later reads the result by pulling chip select and read low. An external comparator reports, for the trial code the block presents, whether the analog input is at or above that code. The block divides its clock by eight to pace the search, decides one bit per internal step with the most significant bit first, copies the finished code into an output latch and signals completion on an active-low interrupt.

The data bus is modelled as an 8-bit value plus an output-enable signal standing for the three-state driver. Feeding the interrupt back into the write input with chip select tied low makes the block convert continuously. In that mode each completion restarts the search at once and the interrupt pulse lasts a single clock.

Top module: `sar_bus_ctrl`

## Requirements
- R1: An internal step occurs once every 8 clocks. During a search the trial code changes exactly at each step, so consecutive changes are 8 clocks apart.
- R2: The first trial of a search is 0x80, with only bit 7 set. At each step the bit under test is kept when `cmp_hi` is 1 (input at or above trial) and cleared when it is 0, and the next lower bit is set for the following trial.
- R3: The latched result is the largest code not above the comparator's threshold. An input at full scale yields 0xFF, and an input of zero yields 0x00.
- R4: While `cs_n` and `wr_n` are both low, the trial code is held at 0, `intr_n` is high, and no search advances, for any length of time.
- R5: Let R be the first rising edge at which `cs_n` and `wr_n` are no longer both low. The first trial (0x80) appears after one of the rising edges R+1 through R+8.
- R6: `intr_n` falls exactly 64 clocks after the rising edge that first presented the 0x80 trial.
- R7: A start command during a search abandons it. No interrupt and no result come from the abandoned search, and the new search runs in full.
- R8: `intr_n` falls at the edge where the result enters the output latch. It then stays low for at least 8 clocks and afterwards until a read or a start.
- R9: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both low, and `dout` then carries the latched result. `dout_oe` is 0 otherwise. A read after the 8-clock set window raises `intr_n` at the next edge.
- R10: With `cs_n` and `rd_n` held low throughout, `intr_n` still falls at the end of a search and is low for exactly 8 clocks.
- R11: With `wr_n` fed from `intr_n` and `cs_n` low, each completion restarts the search. `intr_n` is then low for 1 clock, and successive falls are 67 to 74 clocks apart.
- R12: After reset `intr_n` is 1, `trial_code` is 0 and `dout_oe` is 0 while no read is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write (start) |
| rd_n | input | 1 | Active-low read (output enable) |
| cmp_hi | input | 1 | Comparator result, 1 when the input is at or above `trial_code` |
| trial_code | output | 8 | Trial code for the external DAC and comparator |
| dout | output | 8 | Latched conversion result |
| dout_oe | output | 1 | Data bus drive enable, 0 means high-impedance |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The hardest situations to reach are those where the interrupt's set window overlaps a clearing condition. One is a read held active across the end of a search. The other is free-running operation, where the interrupt itself issues the next start. The bench holds chip select and read low before launching a search and measures the resulting 8-clock pulse. It then switches the write input over to the interrupt output between edges, so the loop closes on a live interrupt, and measures the 1-clock pulses and the restart period. An abort test launches a second start partway through a search with a different comparator threshold, so that any stray completion from the first search shows up as a wrong code.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    localparam int unsigned CODE_BITS = 8;
    localparam int unsigned STEP_LOG2 = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ARM  = 2'd2,
        ST_RUN  = 2'd3
    } conv_state_e;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int unsigned DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [DIV_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign tick = &cnt;

    // R1: steps never come back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_ctl_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start_hold,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] trial,
    output logic              done,
    output logic [CODE_W-1:0] final_code
);
    localparam int unsigned IDX_W = $clog2(CODE_W);
    localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0]  TOP = IDX_W'(CODE_W-1);

    conv_state_e       state;
    logic [CODE_W-1:0] sar;
    logic [IDX_W-1:0]  bitpos;
    logic [CODE_W-1:0] cur_mask;
    logic [CODE_W-1:0] decided;

    assign cur_mask   = ONE << bitpos;
    assign decided    = cmp_hi ? sar : (sar & ~cur_mask);
    assign done       = (state == ST_RUN) && tick && (bitpos == '0) && !start_hold;
    assign final_code = decided;
    assign trial      = sar;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sar    <= '0;
            bitpos <= '0;
        end else if (start_hold) begin
            state  <= ST_HOLD;
            sar    <= '0;
            bitpos <= '0;
        end else begin
            case (state)
                ST_HOLD: state <= ST_ARM;
                ST_ARM: if (tick) begin
                    state  <= ST_RUN;
                    sar    <= ONE << TOP;
                    bitpos <= TOP;
                end
                ST_RUN: if (tick) begin
                    if (bitpos == '0) begin
                        sar   <= decided;
                        state <= ST_IDLE;
                    end else begin
                        sar    <= decided | (cur_mask >> 1);
                        bitpos <= bitpos - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: a start command clears the trial code
    p_hold_clears_r4: assert property (@(posedge clk) disable iff (rst)
        start_hold |=> (trial == '0));
    // R2: the search opens with only the top bit set
    p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM && tick && !start_hold) |=> (trial == (ONE << TOP)));
    // R4: no progress while the start condition is held
    p_hold_state_r4: assert property (@(posedge clk) disable iff (rst)
        start_hold |=> (state == ST_HOLD));
endmodule

// File: rtl/sar_irq.sv
module sar_irq #(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned DIV_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [CODE_W-1:0] code,
    input  logic              start_hold,
    input  logic              read_en,
    output logic [CODE_W-1:0] dout,
    output logic              intr_n
);
    localparam logic [DIV_LOG2-1:0] WIN = {DIV_LOG2{1'b1}};

    logic [CODE_W-1:0]   latch_q;
    logic [DIV_LOG2-1:0] set_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            intr_n  <= 1'b1;
            set_cnt <= '0;
        end else if (start_hold) begin
            intr_n  <= 1'b1;
            set_cnt <= '0;
        end else if (done) begin
            latch_q <= code;
            intr_n  <= 1'b0;
            set_cnt <= WIN;
        end else if (set_cnt != '0) begin
            set_cnt <= set_cnt - 1'b1;
        end else if (read_en) begin
            intr_n  <= 1'b1;
        end
    end

    assign dout = latch_q;

    // R8: completion pulls the interrupt low
    p_done_sets_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !intr_n);
    // R4: a start command releases the interrupt
    p_start_clears_r4: assert property (@(posedge clk) disable iff (rst)
        start_hold |=> intr_n);
    // R10: reads cannot cut the set window short
    p_set_window_r10: assert property (@(posedge clk) disable iff (rst)
        (!intr_n && set_cnt != '0 && !start_hold) |=> !intr_n);
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_ctl_pkg::*;
#(
    parameter int unsigned CODE_W   = CODE_BITS,
    parameter int unsigned DIV_LOG2 = STEP_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] dout,
    output logic              dout_oe,
    output logic              intr_n
);
    logic              tick;
    logic              start_hold;
    logic              read_en;
    logic              done;
    logic [CODE_W-1:0] final_code;

    assign start_hold = !cs_n && !wr_n;
    assign read_en    = !cs_n && !rd_n;
    assign dout_oe    = read_en;

    sar_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    sar_search #(.CODE_W(CODE_W)) u_search (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start_hold(start_hold),
        .cmp_hi    (cmp_hi),
        .trial     (trial_code),
        .done      (done),
        .final_code(final_code)
    );

    sar_irq #(.CODE_W(CODE_W), .DIV_LOG2(DIV_LOG2)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .code      (final_code),
        .start_hold(start_hold),
        .read_en   (read_en),
        .dout      (dout),
        .intr_n    (intr_n)
    );
endmodule

// File: tb/sim_sar_bus_ctrl.sv
module sim_sar_bus_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1;
    logic       fr_mode = 1'b0;
    logic [7:0] vin = 8'd0;
    logic       wr_n, cmp_hi;
    logic [7:0] trial_code, dout;
    logic       dout_oe, intr_n;

    assign wr_n   = fr_mode ? intr_n : wr_drv;
    assign cmp_hi = (vin >= trial_code);

    always #(PERIOD/2) clk = ~clk;

    sar_bus_ctrl u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_hi(cmp_hi), .trial_code(trial_code), .dout(dout),
        .dout_oe(dout_oe), .intr_n(intr_n)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor state
    int   cyc = 0, lat = 0, fall_cnt = 0, last_fall = 0, prev_fall = 0, last_width = 0;
    bit   armed = 0;
    logic prev_intr = 1'b1;
    logic [7:0] prev_trial = 8'd0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (trial_code != 0 && prev_trial == 0) begin
                armed = 1; lat = 0;
            end else if (armed) lat++;
            if (prev_intr && !intr_n) begin
                fall_cnt++;
                prev_fall = last_fall;
                last_fall = cyc;
                check(lat == 64, "R6 latency", lat, 64);
                armed = 0;
                if (exp_q.size() == 0) check(0, "R7 unexpected completion", dout, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(dout == e, "R3 code", dout, e);
                end
            end
            if (!prev_intr && intr_n) last_width = cyc - last_fall;
            prev_trial = trial_code;
            prev_intr  = intr_n;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic start_conv(input logic [7:0] v, input bit push, input bit keep_cs, input int hold);
        int n;
        logic [7:0] t0;
        vin = v;
        if (push) exp_q.push_back(v);
        cs_n = 0; wr_drv = 0;
        repeat (hold) step();
        check(trial_code == 0, "R4 hold trial", trial_code, 0);
        check(intr_n == 1, "R4 hold intr", intr_n, 1);
        wr_drv = 1;
        if (!keep_cs) cs_n = 1;
        n = 0;
        do begin step(); n++; end while (trial_code == 0 && n < 20);
        // first trial seen after edge R+1..R+8 -> sampled 2..9 steps later
        check(n >= 2 && n <= 9, "R5 start delay", n, 2);
        check(trial_code == 8'h80, "R2 first trial", trial_code, 8'h80);
        t0 = trial_code; n = 0;
        do begin step(); n++; end while (trial_code == t0 && n < 20);
        check(n == 8, "R1 step spacing", n, 8);
    endtask

    task automatic wait_eoc();
        int n = 0;
        while (intr_n && n < 200) begin step(); n++; end
        check(!intr_n, "R8 completion seen", intr_n, 0);
    endtask

    task automatic read_clear(input logic [7:0] v);
        repeat (12) step();
        check(!intr_n, "R8 held until read", intr_n, 0);
        check(!dout_oe, "R9 bus idle", dout_oe, 0);
        cs_n = 0; rd_n = 0; #1;
        check(dout_oe, "R9 enable", dout_oe, 1);
        check(dout == v, "R9 data", dout, v);
        step();
        cs_n = 1; rd_n = 1;
        check(intr_n, "R9 read clears", intr_n, 1);
    endtask

    task automatic wait_falls(input int target);
        int n = 0;
        while (fall_cnt < target && n < 1000) begin step(); n++; end
        check(fall_cnt >= target, "R11 restart", fall_cnt, target);
    endtask

    task automatic wait_high();
        int n = 0;
        while (!intr_n && n < 100) begin step(); n++; end
    endtask

    initial begin
        #(PERIOD * 200000);
        check(0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) step();
        rst = 0;
        step();
        // R12 reset state
        check(intr_n == 1, "R12 intr", intr_n, 1);
        check(trial_code == 0, "R12 trial", trial_code, 0);
        check(dout_oe == 0, "R12 bus", dout_oe, 0);

        // main conversions with normal read handshake
        start_conv(8'hB6, 1, 0, 3); wait_eoc(); read_clear(8'hB6);
        start_conv(8'hFF, 1, 0, 3); wait_eoc(); read_clear(8'hFF);  // R3 full scale
        start_conv(8'h00, 1, 0, 3); wait_eoc(); read_clear(8'h00);  // R3 zero
        start_conv(8'h01, 1, 0, 5); wait_eoc(); read_clear(8'h01);
        start_conv(8'h7F, 1, 0, 2); wait_eoc(); read_clear(8'h7F);

        // R4 long hold
        start_conv(8'h3C, 1, 0, 100); wait_eoc(); read_clear(8'h3C);

        // R7 abort: first search discarded
        start_conv(8'h11, 0, 0, 3);
        repeat (20) step();
        check(intr_n, "R7 no early completion", intr_n, 1);
        start_conv(8'hE4, 1, 0, 3); wait_eoc(); read_clear(8'hE4);

        // R10 continuous read
        rd_n = 0;
        start_conv(8'h9A, 1, 1, 3);
        wait_eoc();
        check(dout_oe && dout == 8'h9A, "R10 data on bus", dout, 8'h9A);
        wait_high();
        check(last_width == 8, "R10 pulse width", last_width, 8);
        rd_n = 1; cs_n = 1;

        // R11 free-running mode
        start_conv(8'h5A, 1, 0, 3); wait_eoc();
        repeat (3) exp_q.push_back(8'h5A);
        base = fall_cnt;
        cs_n = 0; fr_mode = 1;
        wait_falls(base + 1);
        wait_high();
        check(last_width == 1, "R11 pulse width", last_width, 1);
        wait_falls(base + 2);
        check(last_fall - prev_fall >= 67 && last_fall - prev_fall <= 74,
              "R11 period", last_fall - prev_fall, 67);
        wait_high();
        check(last_width == 1, "R11 pulse width 2", last_width, 1);
        wait_falls(base + 3);
        fr_mode = 0; wr_drv = 1; cs_n = 1;
        read_clear(8'h5A);
        check(exp_q.size() == 0, "R11 all results", exp_q.size(), 0);

        repeat (5) step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule